// File: doc/BRIEF.md
# Two-Level Fetch Address Tree Cache

This block produces the start addresses of the basic blocks a wide fetch unit reads in one cycle. It looks up a direct-mapped, tagged table using the current fetch address alone. A hit returns a stored binary tree of branch destinations. For prediction level L the tree holds 2^L addresses, so two levels store 2 + 4 = 6 addresses and three levels would store 14. The total always follows from the `LEVELS` parameter as 2^(LEVELS+1) - 2 slots per entry.

One prediction bit per level picks a single path down the tree in the same cycle. Block 0 is the fetch address itself. Block 1 is the taken or fall-through address of the first branch. Block 2 is one of the two addresses under the side chosen at level one. Each branch node also stores a valid flag and a 2-bit kind. When a branch is not conditional, its prediction bit is ignored and the path goes the taken way.

Lookup is purely combinational from the stored state. A fill port writes one whole entry, and the fill becomes visible at the next clock edge.

Top module: `fetch_tree_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup gives `hit` low.
- R2: The entry index is `lookupAddr[6:2]` and the tag is `lookupAddr[31:7]`. Bits [1:0] take no part in the lookup. `hit` is high when the indexed entry is valid and its tag equals the lookup tag.
- R3: On a miss, `blockValid` is all zero and every `blockAddr` field reads zero.
- R4: On a hit, block 0 (`blockAddr[31:0]`) equals `lookupAddr` and `blockValid[0]` is high.
- R5: Block 1 (`blockAddr[63:32]`) is valid when the first-level branch (node 0) is valid. If that branch is taken, block 1 is slot 0. If it falls through, block 1 is slot 1. A conditional branch is taken when `predBits[0]` is 1.
- R6: Block 2 (`blockAddr[95:64]`) comes from the second-level node on the chosen side. On the taken side this is node 1, which uses slot 2 when taken and slot 3 when not. On the fall-through side this is node 2, which uses slot 4 when taken and slot 5 when not. `predBits[1]` decides a conditional node 1 or node 2.
- R7: If the selected second-level node is not valid, only blocks 0 and 1 are flagged valid. Block 2 then reads zero.
- R8: The kind code is 00 for conditional, 01 for unconditional, 10 for return and 11 for no branch. Any code other than 00 forces the taken direction whatever the prediction bit says.
- R9: While `fillEn` is high, the entry at index `fillAddr[6:2]` is written at the clock edge. That entry gets tag `fillAddr[31:7]` and valid bits `fillBrValid`, where bit n belongs to node n. It gets kinds `fillBrType`, where bits [2n+1:2n] belong to node n. It gets targets `fillTargets`, where slot s sits at bits [32s+31:32s]. A lookup in the same cycle sees the old contents. A lookup from the next cycle on sees the new contents.
- R10: If the first-level branch is not valid, only block 0 is flagged valid, and blocks 1 and 2 read zero.
- R11: A fill with a different tag at an index that is already occupied replaces the entry, so the old tag misses from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lookupAddr | input | 32 | Fetch address to look up |
| predBits | input | 2 | Prediction per level, 1 means taken |
| hit | output | 1 | Tag match on a valid entry |
| blockValid | output | 3 | Valid flag for each block start address |
| blockAddr | output | 96 | Block start addresses, block k at bits [32k+31:32k] |
| fillEn | input | 1 | Write an entry this cycle |
| fillAddr | input | 32 | Address that provides the index and tag of the written entry |
| fillBrValid | input | 3 | Per-node branch valid flags |
| fillBrType | input | 6 | Per-node 2-bit branch kind |
| fillTargets | input | 192 | Six stored addresses, slot s at bits [32s+31:32s] |

## Verification
The hardest situations to reach from the ports combine a fall-through first branch with a forced-taken or invalid second-level node on the fall-through side. They also include a lookup that lands on the very entry being filled in the same cycle. The stimulus reaches the first case by filling every entry with random kinds and valid masks and then sweeping all four prediction patterns over each entry. Directed entries add conditional and forced kinds with every valid mask. For the second case, the lookup address is set equal to the fill address on every fill cycle, and index collisions with fresh tags are mixed into a long random phase.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int MAX_LVL = 4;

  typedef enum logic [1:0] {
    KIND_COND   = 2'b00,
    KIND_UNCOND = 2'b01,
    KIND_RET    = 2'b10,
    KIND_NONE   = 2'b11
  } brKind_e;

  typedef struct packed {
    logic               wrEn;
    logic [MAX_LVL-1:0] takeBit;
    logic [MAX_LVL:0]   lvlValid;
  } ftcStrobe_t;
endpackage

// File: rtl/ftc_ctrl.sv
module ftc_ctrl import ftc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int OFF_W  = 2,
  parameter int LEVELS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     lookupAddr,
  input  logic [LEVELS-1:0]     predBits,
  input  logic                  fillEn,
  input  logic [ADDR_W-1:0]     fillAddr,
  input  logic [(1<<LEVELS)-2:0] fillBrValid,
  input  logic [2*((1<<LEVELS)-1)-1:0] fillBrType,
  output ftcStrobe_t            strobe
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int NODES   = (1 << LEVELS) - 1;

  logic [TAG_W-1:0]   tagMem    [ENTRIES];
  logic [NODES-1:0]   brValidMem[ENTRIES];
  logic [2*NODES-1:0] brKindMem [ENTRIES];
  logic [ENTRIES-1:0] entValid;

  logic [IDX_W-1:0] lIdx, fIdx;
  logic [TAG_W-1:0] lTag, fTag;
  logic             unusedOff;

  assign lIdx = lookupAddr[OFF_W +: IDX_W];
  assign lTag = lookupAddr[ADDR_W-1 -: TAG_W];
  assign fIdx = fillAddr[OFF_W +: IDX_W];
  assign fTag = fillAddr[ADDR_W-1 -: TAG_W];
  assign unusedOff = ^{lookupAddr[OFF_W-1:0], fillAddr[OFF_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) entValid <= '0;
    else if (fillEn) entValid[fIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fillEn) begin
      tagMem[fIdx]     <= fTag;
      brValidMem[fIdx] <= fillBrValid;
      brKindMem[fIdx]  <= fillBrType;
    end
  end

  logic [LEVELS-1:0] nodeIdx;
  logic [1:0]        kind;
  logic              take;

  always_comb begin
    strobe             = '0;
    strobe.wrEn        = fillEn;
    strobe.lvlValid[0] = entValid[lIdx] && (tagMem[lIdx] == lTag);
    nodeIdx = '0;
    kind    = '0;
    take    = 1'b0;
    for (int k = 0; k < LEVELS; k++) begin
      kind = brKindMem[lIdx][{nodeIdx, 1'b0} +: 2];
      take = (kind == KIND_COND) ? predBits[k] : 1'b1;
      strobe.takeBit[k]    = take;
      strobe.lvlValid[k+1] = strobe.lvlValid[k] & brValidMem[lIdx][nodeIdx];
      nodeIdx = LEVELS'(2 * int'(nodeIdx) + (take ? 1 : 2));
    end
  end
endmodule

// File: rtl/ftc_datapath.sv
module ftc_datapath import ftc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int OFF_W  = 2,
  parameter int LEVELS = 2
) (
  input  logic                          clk,
  input  ftcStrobe_t                    strobe,
  input  logic [ADDR_W-1:0]             lookupAddr,
  input  logic [ADDR_W-1:0]             fillAddr,
  input  logic [((2<<LEVELS)-2)*ADDR_W-1:0] fillTargets,
  output logic [(LEVELS+1)*ADDR_W-1:0]  blockAddr
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int NSLOT   = (2 << LEVELS) - 2;
  localparam int ROW_W   = NSLOT * ADDR_W;

  logic [ROW_W-1:0] addrMem [ENTRIES];
  logic [ROW_W-1:0] row;
  logic [IDX_W-1:0] lIdx, fIdx;

  assign lIdx = lookupAddr[OFF_W +: IDX_W];
  assign fIdx = fillAddr[OFF_W +: IDX_W];
  assign row  = addrMem[lIdx];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) addrMem[fIdx] <= fillTargets;
  end

  logic [LEVELS:0] slot, nodeIdx;

  always_comb begin
    blockAddr = '0;
    blockAddr[ADDR_W-1:0] = strobe.lvlValid[0] ? lookupAddr : '0;
    nodeIdx = '0;
    slot    = '0;
    for (int k = 0; k < LEVELS; k++) begin
      slot    = (LEVELS+1)'(2 * int'(nodeIdx) + (strobe.takeBit[k] ? 0 : 1));
      blockAddr[(k+1)*ADDR_W +: ADDR_W] =
        strobe.lvlValid[k+1] ? row[int'(slot)*ADDR_W +: ADDR_W] : '0;
      nodeIdx = slot + 1'b1;
    end
  end
endmodule

// File: rtl/fetch_tree_cache.sv
module fetch_tree_cache import ftc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int OFF_W  = 2,
  parameter int LEVELS = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [ADDR_W-1:0]                    lookupAddr,
  input  logic [LEVELS-1:0]                    predBits,
  output logic                                 hit,
  output logic [LEVELS:0]                      blockValid,
  output logic [(LEVELS+1)*ADDR_W-1:0]         blockAddr,
  input  logic                                 fillEn,
  input  logic [ADDR_W-1:0]                    fillAddr,
  input  logic [(1<<LEVELS)-2:0]               fillBrValid,
  input  logic [2*((1<<LEVELS)-1)-1:0]         fillBrType,
  input  logic [((2<<LEVELS)-2)*ADDR_W-1:0]    fillTargets
);
  ftcStrobe_t strobe;
  logic       unusedStrobe;

  ftc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .lookupAddr(lookupAddr), .predBits(predBits),
    .fillEn(fillEn), .fillAddr(fillAddr), .fillBrValid(fillBrValid),
    .fillBrType(fillBrType), .strobe(strobe)
  );

  ftc_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)) u_dp (
    .clk(clk), .strobe(strobe), .lookupAddr(lookupAddr), .fillAddr(fillAddr),
    .fillTargets(fillTargets), .blockAddr(blockAddr)
  );

  assign hit          = strobe.lvlValid[0];
  assign blockValid   = strobe.lvlValid[LEVELS:0];
  assign unusedStrobe = ^strobe;
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int OFF_W  = 2,
  parameter int LEVELS = 2
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [ADDR_W-1:0]                 lookupAddr,
  input logic [LEVELS-1:0]                 predBits,
  input logic                              hit,
  input logic [LEVELS:0]                   blockValid,
  input logic [(LEVELS+1)*ADDR_W-1:0]      blockAddr,
  input logic                              fillEn,
  input logic [ADDR_W-1:0]                 fillAddr,
  input logic [(1<<LEVELS)-2:0]            fillBrValid,
  input logic [2*((1<<LEVELS)-1)-1:0]      fillBrType,
  input logic [((2<<LEVELS)-2)*ADDR_W-1:0] fillTargets
);
  // R3
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (blockValid == '0 && blockAddr == '0));

  // R4
  root_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (blockValid[0] && blockAddr[ADDR_W-1:0] == lookupAddr));

  // R9
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fillEn |=> (lookupAddr[ADDR_W-1:OFF_W] != $past(fillAddr[ADDR_W-1:OFF_W]) || hit));

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    // R7
    path_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blockValid[k+1] |-> blockValid[k]);
    // R10
    invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !blockValid[k+1] |-> blockAddr[(k+1)*ADDR_W +: ADDR_W] == '0);
  end
endmodule

bind fetch_tree_cache ftc_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)) u_chk (.*);

// File: tb/fetch_tree_cache_bench.sv
module fetch_tree_cache_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  lookupAddr = '0;
  logic [1:0]   predBits = '0;
  logic         hit;
  logic [2:0]   blockValid;
  logic [95:0]  blockAddr;
  logic         fillEn = 1'b0;
  logic [31:0]  fillAddr = '0;
  logic [2:0]   fillBrValid = '0;
  logic [5:0]   fillBrType = '0;
  logic [191:0] fillTargets = '0;

  int checks = 0;
  int fails  = 0;

  bit [24:0] mTag [32];
  bit        mV   [32];
  bit [2:0]  mBrV [32];
  bit [5:0]  mTy  [32];
  bit [31:0] mA   [32][6];

  always #10 clk = ~clk;

  fetch_tree_cache u_fetch_tree_cache (
    .clk(clk), .rst_n(rst_n), .lookupAddr(lookupAddr), .predBits(predBits),
    .hit(hit), .blockValid(blockValid), .blockAddr(blockAddr),
    .fillEn(fillEn), .fillAddr(fillAddr), .fillBrValid(fillBrValid),
    .fillBrType(fillBrType), .fillTargets(fillTargets)
  );

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    bit [4:0]  idx;
    bit        eHit, t1, t2;
    bit [2:0]  eVal;
    bit [95:0] eAddr;
    int        side;
    idx   = lookupAddr[6:2];
    eHit  = mV[idx] && (mTag[idx] == lookupAddr[31:7]);
    eVal  = '0;
    eAddr = '0;
    if (eHit) begin
      eVal[0] = 1'b1;
      eAddr[31:0] = lookupAddr;
      if (mBrV[idx][0]) begin
        t1 = (mTy[idx][1:0] != 2'b00) || predBits[0];
        eVal[1] = 1'b1;
        eAddr[63:32] = t1 ? mA[idx][0] : mA[idx][1];
        side = t1 ? 1 : 2;
        if (mBrV[idx][side]) begin
          t2 = (mTy[idx][2*side +: 2] != 2'b00) || predBits[1];
          eVal[2] = 1'b1;
          if (t1) eAddr[95:64] = t2 ? mA[idx][2] : mA[idx][3];
          else    eAddr[95:64] = t2 ? mA[idx][4] : mA[idx][5];
        end
      end
    end
    check("R1 R2 R9 R11 hit", {95'b0, hit}, {95'b0, eHit});
    check("R3 R5 R6 R7 R8 R10 blockValid", {93'b0, blockValid}, {93'b0, eVal});
    check("R3 R4 R5 R6 R7 R8 blockAddr", blockAddr, eAddr);
  endtask

  task automatic cycle();
    bit [4:0] fi;
    #14;
    compare();
    @(posedge clk);
    if (fillEn) begin
      fi = fillAddr[6:2];
      mV[fi]   = 1'b1;
      mTag[fi] = fillAddr[31:7];
      mBrV[fi] = fillBrValid;
      mTy[fi]  = fillBrType;
      for (int s = 0; s < 6; s++) mA[fi][s] = fillTargets[32*s +: 32];
    end
    #1;
  endtask

  task automatic fill(input bit [31:0] a, input bit [2:0] v, input bit [5:0] ty);
    fillEn      = 1'b1;
    fillAddr    = a;
    fillBrValid = v;
    fillBrType  = ty;
    for (int s = 0; s < 6; s++) fillTargets[32*s +: 32] = $urandom;
    lookupAddr  = a;   // R9 same-cycle lookup sees old contents
    predBits    = 2'($urandom);
    cycle();
    fillEn = 1'b0;
  endtask

  task automatic look(input bit [31:0] a, input bit [1:0] p);
    lookupAddr = a;
    predBits   = p;
    cycle();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mV[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: nothing hits after reset
    for (int i = 0; i < 8; i++) look($urandom, 2'(i));
    // R9: fill every index with random contents
    for (int i = 0; i < 32; i++)
      fill({25'($urandom), 5'(i), 2'b00}, 3'($urandom), 6'($urandom));
    // R2 R5 R6: sweep entries and prediction patterns, offset bits random
    for (int i = 0; i < 32; i++)
      for (int p = 0; p < 4; p++)
        look({mTag[i], 5'(i), 2'($urandom)}, 2'(p));
    // R7 R8 R10: directed kind and valid combinations at index 3
    for (int v = 0; v < 8; v++)
      for (int t = 0; t < 4; t++) begin
        fill({25'h1abcd, 5'd3, 2'b00}, 3'(v), {2'(t), 2'(t + 1), 2'(t)});
        for (int p = 0; p < 4; p++) look({25'h1abcd, 5'd3, 2'b01}, 2'(p));
      end
    // R11: different tag at occupied index replaces it
    fill({25'h0f0f0, 5'd3, 2'b00}, 3'b111, 6'b0);
    look({25'h1abcd, 5'd3, 2'b00}, 2'b11);
    look({25'h0f0f0, 5'd3, 2'b00}, 2'b10);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit [4:0] ri;
      ri = 5'($urandom);
      if ($urandom % 5 == 0)
        fill({($urandom % 2 == 0) ? mTag[ri] : 25'($urandom), ri, 2'b00},
             3'($urandom), 6'($urandom));
      else
        look({($urandom % 8 == 0) ? 25'($urandom) : mTag[ri], ri, 2'($urandom)},
             2'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule